// File: doc/BRIEF.md
# Configuration Window Base Register and Decoder

This block holds one 64-bit base register that places a memory-mapped configuration window in a 39-bit physical address space, and decodes incoming memory request addresses against that window. Software writes the register through a simple write port with byte enables, and can read it back at any time. The register holds an enable bit, a two-bit window length code and the eleven upper base-address bits. Every other bit reads as zero and cannot be written.

Each request address arrives with a valid strobe. When the window is enabled and the address falls inside it, the block raises `hit` in the same cycle. It also splits the address into a bus number, a device number, a function number and a byte offset inside that function's 4 KB block. Each bus spans 1 MB, each device 32 KB and each function 4 KB. The request stream has no ready signal: the decoder is purely combinational, accepts a request in every cycle and never applies back-pressure, so the requester can present a new address on every clock.

A secure-mode lock input freezes the register for as long as it is high. Register writes take effect on the clock edge that samples them.

Top module: `cfgwin_decoder`

## Requirements
- R1: After reset the register reads as all zeros and no request address produces a hit.
- R2: Only bit 0 (enable), bits 2:1 (length code) and bits 38:28 (base) can be written. All other bits, including 63:39, always read as zero.
- R3: Byte `k` of the register takes byte `k` of `wr_data` when `wr_en` and `wr_be[k]` are both high at a clock edge. Bytes whose enable is low keep their value. The new value appears on `rd_data` after that edge.
- R4: While bit 0 of the register is 0, `hit` stays low.
- R5: While `lock` is high, writes leave the register unchanged.
- R6: A request address with any of bits 63:39 set never hits.
- R7: Length code 00 selects a 256 MB window with no further constraint. Code 01 selects a 128 MB window and additionally requires address bit 27 = 0. Code 10 selects a 64 MB window and additionally requires address bits 27:26 = 0. Code 11 is reserved and never hits.
- R8: `hit` is high only when `req_valid` is high and address bits 38:28 equal register bits 38:28. `hit` follows the address combinationally within the same cycle.
- R9: On a hit, `bus` = addr[27:20], `dev` = addr[19:15], `fn` = addr[14:12] and `offset` = addr[11:0]. `bus` is masked to the bus count of the window size. When there is no hit, all four outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lock | input | 1 | Secure-mode lock; blocks register writes while high |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 8 | Byte enables for the write |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Stored register value; non-writable bits read as zero |
| req_valid | input | 1 | Request address is valid |
| req_addr | input | 64 | Request memory address |
| hit | output | 1 | Address falls inside the enabled window |
| bus | output | 8 | Bus number of the hit |
| dev | output | 5 | Device number of the hit |
| fn | output | 3 | Function number of the hit |
| offset | output | 12 | Byte offset within the 4 KB function block |

## Verification
The properties assume that `rst` is held for at least one clock edge before any check counts, and that `req_addr` and `req_valid` are stable whenever the outputs are sampled. The bench drives all inputs on the falling edge and samples half a period later, so both assumptions hold. The lock property also assumes that the only path to a register change is the write port. The stimulus respects this by changing the register only through `wr_en`, and it raises `lock` before the write it is meant to block.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  localparam int REG_W    = 64;
  localparam int ADDR_W   = 64;
  localparam int PA_W     = 39;
  localparam int BASE_LSB = 28;
  localparam int BUS_W    = 8;
  localparam int DEV_W    = 5;
  localparam int FN_W     = 3;
  localparam int OFS_W    = 12;

  typedef enum logic [1:0] {
    WIN_256M = 2'b00,
    WIN_128M = 2'b01,
    WIN_64M  = 2'b10,
    WIN_NONE = 2'b11
  } win_len_e;

  // Bits that software may change: enable, length code, base field.
  function automatic logic [REG_W-1:0] writable_mask();
    logic [REG_W-1:0] m;
    m = '0;
    m[2:0] = 3'b111;
    for (int i = BASE_LSB; i < PA_W; i++) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/cfgwin_regfile.sv
module cfgwin_regfile
  import cfgwin_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           lock,
  input  logic           wr_en,
  input  logic [W/8-1:0] wr_be,
  input  logic [W-1:0]   wr_data,
  output logic [W-1:0]   q
);
  localparam int NBYTES = W / 8;
  localparam logic [W-1:0] MASK = W'(writable_mask());

  logic [W-1:0] d;
  logic         wr_ok;

  assign wr_ok = wr_en && !lock;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign d[b*8 +: 8] = (wr_ok && wr_be[b]) ? (wr_data[b*8 +: 8] & MASK[b*8 +: 8])
                                             : q[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/cfgwin_match.sv
module cfgwin_match
  import cfgwin_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int PW  = PA_W,
  parameter int BL  = BASE_LSB
) (
  input  logic           req_valid,
  input  logic [AW-1:0]  req_addr,
  input  logic           enable,
  input  win_len_e       len,
  input  logic [PW-BL-1:0] base,
  output logic           hit
);
  logic upper_ok, base_ok, size_ok;

  if (AW > PW) begin : g_upper
    assign upper_ok = (req_addr[AW-1:PW] == '0);
  end else begin : g_noupper
    assign upper_ok = 1'b1;
  end

  assign base_ok = (req_addr[PW-1:BL] == base);

  always_comb begin
    unique case (len)
      WIN_256M: size_ok = 1'b1;
      WIN_128M: size_ok = !req_addr[BL-1];
      WIN_64M:  size_ok = (req_addr[BL-1:BL-2] == 2'b00);
      default:  size_ok = 1'b0;
    endcase
  end

  assign hit = req_valid && enable && upper_ok && base_ok && size_ok;
endmodule

// File: rtl/cfgwin_fields.sv
module cfgwin_fields
  import cfgwin_pkg::*;
#(
  parameter int BL = BASE_LSB
) (
  input  logic             hit,
  input  win_len_e         len,
  input  logic [BL-1:0]    addr_lo,
  output logic [BUS_W-1:0] bus,
  output logic [DEV_W-1:0] dev,
  output logic [FN_W-1:0]  fn,
  output logic [OFS_W-1:0] offset
);
  localparam int FN_LSB  = OFS_W;
  localparam int DEV_LSB = FN_LSB + FN_W;
  localparam int BUS_LSB = DEV_LSB + DEV_W;

  logic [BUS_W-1:0] bus_mask;

  always_comb begin
    unique case (len)
      WIN_128M: bus_mask = {1'b0, {(BUS_W-1){1'b1}}};
      WIN_64M:  bus_mask = {2'b00, {(BUS_W-2){1'b1}}};
      default:  bus_mask = '1;
    endcase
  end

  assign bus    = hit ? (addr_lo[BUS_LSB +: BUS_W] & bus_mask) : '0;
  assign dev    = hit ? addr_lo[DEV_LSB +: DEV_W] : '0;
  assign fn     = hit ? addr_lo[FN_LSB +: FN_W]   : '0;
  assign offset = hit ? addr_lo[0 +: OFS_W]       : '0;
endmodule

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder
  import cfgwin_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               lock,
  input  logic               wr_en,
  input  logic [REG_W/8-1:0] wr_be,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               hit,
  output logic [BUS_W-1:0]   bus,
  output logic [DEV_W-1:0]   dev,
  output logic [FN_W-1:0]    fn,
  output logic [OFS_W-1:0]   offset
);
  logic [REG_W-1:0] reg_q;
  win_len_e         len;

  cfgwin_regfile #(.W(REG_W)) u_reg (
    .clk(clk), .rst(rst), .lock(lock),
    .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .q(reg_q)
  );

  assign len     = win_len_e'(reg_q[2:1]);
  assign rd_data = reg_q;

  cfgwin_match #(.AW(ADDR_W), .PW(PA_W), .BL(BASE_LSB)) u_match (
    .req_valid(req_valid), .req_addr(req_addr),
    .enable(reg_q[0]), .len(len), .base(reg_q[PA_W-1:BASE_LSB]),
    .hit(hit)
  );

  cfgwin_fields #(.BL(BASE_LSB)) u_fields (
    .hit(hit), .len(len), .addr_lo(req_addr[BASE_LSB-1:0]),
    .bus(bus), .dev(dev), .fn(fn), .offset(offset)
  );
endmodule

// File: rtl/cfgwin_decoder_chk.sv
module cfgwin_decoder_chk
  import cfgwin_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               lock,
  input logic [REG_W-1:0]   rd_data,
  input logic               req_valid,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               hit,
  input logic [BUS_W-1:0]   bus,
  input logic [DEV_W-1:0]   dev,
  input logic [FN_W-1:0]    fn,
  input logic [OFS_W-1:0]   offset
);
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_data[REG_W-1:PA_W] == '0) && (rd_data[BASE_LSB-1:3] == '0));

  p_lock_hold_r5: assert property (@(posedge clk) disable iff (rst)
    lock |=> (rd_data == $past(rd_data)));

  p_no_hit_disabled_r4: assert property (@(posedge clk) disable iff (rst)
    !rd_data[0] |-> !hit);

  p_no_hit_high_addr_r6: assert property (@(posedge clk) disable iff (rst)
    (req_addr[ADDR_W-1:PA_W] != '0) |-> !hit);

  p_no_hit_rsvd_len_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_data[2:1] == 2'b11) |-> !hit);

  p_bus_in_window_r7: assert property (@(posedge clk) disable iff (rst)
    (hit && rd_data[2:1] == 2'b01) |-> !bus[BUS_W-1]);

  p_hit_needs_valid_r8: assert property (@(posedge clk) disable iff (rst)
    hit |-> (req_valid && req_addr[PA_W-1:BASE_LSB] == rd_data[PA_W-1:BASE_LSB]));

  p_fields_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (bus == '0 && dev == '0 && fn == '0 && offset == '0));
endmodule

bind cfgwin_decoder cfgwin_decoder_chk u_chk (
  .clk(clk), .rst(rst), .lock(lock), .rd_data(rd_data),
  .req_valid(req_valid), .req_addr(req_addr), .hit(hit),
  .bus(bus), .dev(dev), .fn(fn), .offset(offset)
);

// File: tb/cfgwin_decoder_test.sv
module cfgwin_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lock = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_be = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        hit;
  logic [7:0]  bus;
  logic [4:0]  dev;
  logic [2:0]  fn;
  logic [11:0] offset;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfgwin_decoder uut (
    .clk(clk), .rst(rst), .lock(lock), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .rd_data(rd_data), .req_valid(req_valid),
    .req_addr(req_addr), .hit(hit), .bus(bus), .dev(dev), .fn(fn),
    .offset(offset)
  );

  typedef struct packed {
    logic [63:0] addr;
    logic        hit;
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  fn;
    logic [11:0] off;
  } vec_t;

  // Window: base field 0x7F, length code 00, enabled.
  localparam vec_t VECS [8] = '{
    '{64'h0000_0007_F000_0000, 1'b1, 8'h00, 5'h00, 3'h0, 12'h000},
    '{64'h0000_0007_F051_A1A4, 1'b1, 8'h05, 5'h03, 3'h2, 12'h1A4},
    '{64'h0000_0007_FFFF_FFFF, 1'b1, 8'hFF, 5'h1F, 3'h7, 12'hFFF},
    '{64'h0000_0006_FFFF_FFFF, 1'b0, 8'h00, 5'h00, 3'h0, 12'h000},
    '{64'h0000_0008_0000_0000, 1'b0, 8'h00, 5'h00, 3'h0, 12'h000},
    '{64'h0800_0007_F000_0000, 1'b0, 8'h00, 5'h00, 3'h0, 12'h000},
    '{64'h0000_0007_F800_0000, 1'b1, 8'h80, 5'h00, 3'h0, 12'h000},
    '{64'h0000_0007_F00F_FFFF, 1'b1, 8'h00, 5'h1F, 3'h7, 12'hFFF}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] be, input logic [63:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_be = be; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic probe(input logic v, input logic [63:0] a);
    @(negedge clk);
    req_valid = v; req_addr = a;
    #2;
  endtask

  function automatic logic [63:0] outs();
    return {35'd0, hit, bus, dev, fn, offset};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    probe(1'b1, 64'h0);
    check("R1 reset value", rd_data, 64'h0);
    check("R1 no hit after reset", {63'd0, hit}, 64'h0);

    // R2: only writable bits stick; R7: code 11 never hits
    write_reg(8'hFF, '1);
    check("R2 writable mask", rd_data, 64'h0000_007F_F000_0007);
    probe(1'b1, 64'h0000_007F_F000_0000);
    check("R7 reserved length no hit", {63'd0, hit}, 64'h0);

    // R3: byte enables
    write_reg(8'h0F, 64'h0);
    check("R3 low half cleared", rd_data, 64'h0000_007F_0000_0000);
    write_reg(8'hF0, 64'h0);
    check("R3 high half cleared", rd_data, 64'h0);

    // Program the window, then walk the vector table (R6 R8 R9)
    write_reg(8'hFF, 64'h0000_0007_F000_0001);
    check("R3 full write", rd_data, 64'h0000_0007_F000_0001);
    foreach (VECS[i]) begin
      probe(1'b1, VECS[i].addr);
      check($sformatf("R8 R9 R6 vector %0d", i), outs(),
            {35'd0, VECS[i].hit, VECS[i].bus, VECS[i].dev, VECS[i].fn, VECS[i].off});
    end

    // R8: no valid, no hit
    probe(1'b0, 64'h0000_0007_F051_A1A4);
    check("R8 valid low", outs(), 64'h0);

    // R4: enable cleared
    write_reg(8'h01, 64'h0);
    probe(1'b1, 64'h0000_0007_F000_0000);
    check("R4 disabled no hit", {63'd0, hit}, 64'h0);

    // R7: 128 MB window
    write_reg(8'hFF, 64'h0000_0007_F000_0003);
    probe(1'b1, 64'h0000_0007_F800_0000);
    check("R7 128M addr27 miss", {63'd0, hit}, 64'h0);
    probe(1'b1, 64'h0000_0007_F7F0_0000);
    check("R7 128M top bus", outs(), {35'd0, 1'b1, 8'h7F, 5'h0, 3'h0, 12'h0});

    // R7: 64 MB window
    write_reg(8'hFF, 64'h0000_0007_F000_0005);
    probe(1'b1, 64'h0000_0007_F400_0000);
    check("R7 64M addr26 miss", {63'd0, hit}, 64'h0);
    probe(1'b1, 64'h0000_0007_F3F0_0000);
    check("R7 64M top bus", outs(), {35'd0, 1'b1, 8'h3F, 5'h0, 3'h0, 12'h0});

    // R5: lock blocks writes
    write_reg(8'hFF, 64'h0000_0007_F000_0001);
    @(negedge clk);
    lock = 1'b1;
    write_reg(8'hFF, 64'h0);
    check("R5 locked register unchanged", rd_data, 64'h0000_0007_F000_0001);
    probe(1'b1, 64'h0000_0007_F000_0000);
    check("R5 hit survives locked write", {63'd0, hit}, 64'h1);
    @(negedge clk);
    lock = 1'b0;
    write_reg(8'hFF, 64'h0);
    check("R5 write after unlock", rd_data, 64'h0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule